// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Delay Timer

This block is the timing engine of an SPI master. On a start strobe it takes one frame's timing attributes and does three things in turn. First it waits a lead delay that separates chip-select assertion from serial clock activity. It then drives the serial clock through twice as many edges as the frame has bits. Finally it waits a trail delay before chip-select may be released. A one-cycle done pulse follows. The shift register, the FIFOs and the register interface sit outside the block. They watch `busy` (which frames chip-select) and the `sck` edges.

The clock period is the product of a small non-power-of-two prescaler and a stepped scaler. Each of the two delays has its own prescaler, which is multiplied by a power of two. All attributes are captured at the start strobe, so the surrounding logic may change them while a frame runs.

Top module: `spi_sck_timer`

## Requirements
- R1: The SCK period in clock cycles is P = prescale × scale. The 2-bit `baud_pre` selects prescale 2, 3, 5 or 7 for codes 0, 1, 2 and 3. Each period has a phase with `sck` high lasting floor(P/2) cycles and a phase with `sck` low lasting the remaining P − floor(P/2) cycles.
- R2: The 4-bit `baud_sc` selects the scale. Codes 0 to 3 give 2, 4, 6 and 8. Codes 4 to 15 give 2^code, which runs from 16 up to 32768.
- R3: The lead delay is L = m × 2^(`lead_sc`+1) cycles, where `lead_pre` codes 0 to 3 give m = 1, 3, 5 and 7. `busy` rises the cycle after start is sampled. The first `sck` edge comes L cycles plus one phase (at the idle level) after that.
- R4: The trail delay is T = m × 2^(`trail_sc`+1) cycles, using the same multiplier encoding with `trail_pre`. `busy` stays high for exactly T cycles after the last `sck` edge.
- R5: A frame of N bits (`frame_bits`) produces exactly 2N `sck` edges. The first phase is at the `cpol` level and the second at the opposite level. `sck` ends at the `cpol` level.
- R6: `done` is high for exactly one cycle, in the first cycle in which `busy` is low again. `busy` lasts L + N×P + T cycles in total.
- R7: A start strobe while `busy` is high is ignored. Changes to the attribute inputs during a frame do not alter it.
- R8: While idle, `sck` follows `cpol` with a one-cycle register delay.
- R9: When `frame_bits` is 0, the frame has no `sck` edges and `busy` lasts L + T cycles.
- R10: The synchronous reset `rst` stops any frame at once. After reset `busy` and `done` are low and `sck` holds the `cpol` level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a frame (sampled while idle) |
| cpol | input | 1 | Serial clock idle level |
| frame_bits | input | FW | Bits per frame |
| baud_pre | input | 2 | Baud prescaler code |
| baud_sc | input | 4 | Baud scaler code |
| lead_pre | input | 2 | Lead delay prescaler code |
| lead_sc | input | 4 | Lead delay exponent code |
| trail_pre | input | 2 | Trail delay prescaler code |
| trail_sc | input | 4 | Trail delay exponent code |
| sck | output | 1 | Serial clock |
| busy | output | 1 | Frame in progress (chip-select window) |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A corrupted down-counter or wrongly decoded code value shows up at the ports within one frame. It moves the first `sck` edge, stretches a phase, or shifts the falling edge of `busy` by a predictable number of cycles. A miscounted edge counter leaves `sck` resting at the wrong level, or adds or drops edges, and this is visible as soon as `busy` falls. The bench measures, for each frame, the offset of the first edge, the spacing of the first two edges, the number of edges, the trail length and the placement of `done`. It then compares these against values computed from the code tables.

// File: rtl/spi_sck_timer.sv
module spi_sck_timer #(
  parameter int FW = 5,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          cpol,
  input  logic [FW-1:0] frame_bits,
  input  logic [1:0]    baud_pre,
  input  logic [3:0]    baud_sc,
  input  logic [1:0]    lead_pre,
  input  logic [3:0]    lead_sc,
  input  logic [1:0]    trail_pre,
  input  logic [3:0]    trail_sc,
  output logic          sck,
  output logic          busy,
  output logic          done
);
  localparam int EW = FW + 1;

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] per_q;
  logic [CW-1:0] trl_q;
  logic [EW-1:0] edges;

  function automatic logic [CW-1:0] baud_period(input logic [1:0] p, input logic [3:0] s);
    logic [CW-1:0] pv, sv;
    case (p)
      2'd0:    pv = CW'(2);
      2'd1:    pv = CW'(3);
      2'd2:    pv = CW'(5);
      default: pv = CW'(7);
    endcase
    if (s < 4'd4) sv = CW'({s, 1'b0}) + CW'(2);
    else          sv = CW'(1) << s;
    return pv * sv;
  endfunction

  function automatic logic [CW-1:0] delay_len(input logic [1:0] p, input logic [3:0] s);
    logic [CW-1:0] pv;
    pv = CW'({p, 1'b1});
    return pv << ({1'b0, s} + 5'd1);
  endfunction

  function automatic logic [CW-1:0] phase_len(input logic lvl, input logic [CW-1:0] per);
    return lvl ? (per >> 1) : (per - (per >> 1));
  endfunction

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      per_q <= '0;
      trl_q <= '0;
      edges <= '0;
      sck   <= cpol;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          sck <= cpol;
          if (start) begin
            per_q <= baud_period(baud_pre, baud_sc);
            trl_q <= delay_len(trail_pre, trail_sc);
            edges <= {frame_bits, 1'b0};
            cnt   <= delay_len(lead_pre, lead_sc) - CW'(1);
            st    <= S_LEAD;
          end
        end
        S_LEAD: begin
          if (cnt == '0) begin
            if (edges == '0) begin
              st  <= S_TRAIL;
              cnt <= trl_q - CW'(1);
            end else begin
              st  <= S_SHIFT;
              cnt <= phase_len(sck, per_q) - CW'(1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_SHIFT: begin
          if (cnt == '0) begin
            sck   <= ~sck;
            edges <= edges - EW'(1);
            if (edges == EW'(1)) begin
              st  <= S_TRAIL;
              cnt <= trl_q - CW'(1);
            end else begin
              cnt <= phase_len(~sck, per_q) - CW'(1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_sck_timer_chk.sv
module spi_sck_timer_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic cpol,
  input logic sck,
  input logic busy,
  input logic done
);
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r8_idle_follows_cpol: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst)) |-> (sck == $past(cpol)));

  a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  a_r5_sck_idle_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (sck == $past(sck)));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!busy && !done));
endmodule

bind spi_sck_timer spi_sck_timer_chk i_chk (
  .clk(clk), .rst(rst), .start(start), .cpol(cpol),
  .sck(sck), .busy(busy), .done(done)
);

// File: tb/test_spi_sck_timer.sv
module test_spi_sck_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       cpol = 1'b0;
  logic [4:0] frame_bits = '0;
  logic [1:0] baud_pre = '0, lead_pre = '0, trail_pre = '0;
  logic [3:0] baud_sc = '0, lead_sc = '0, trail_sc = '0;
  logic       sck, busy, done;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  spi_sck_timer i_spi_sck_timer (
    .clk(clk), .rst(rst), .start(start), .cpol(cpol), .frame_bits(frame_bits),
    .baud_pre(baud_pre), .baud_sc(baud_sc), .lead_pre(lead_pre), .lead_sc(lead_sc),
    .trail_pre(trail_pre), .trail_sc(trail_sc), .sck(sck), .busy(busy), .done(done)
  );

  // {cpol, bits, baud_pre, baud_sc, lead_pre, lead_sc, trail_pre, trail_sc}
  localparam logic [23:0] VEC [8] = '{
    {1'b0, 5'd8,  2'd0, 4'd0, 2'd0, 4'd0, 2'd0, 4'd0},
    {1'b1, 5'd8,  2'd1, 4'd1, 2'd1, 4'd1, 2'd2, 4'd2},
    {1'b0, 5'd4,  2'd2, 4'd3, 2'd3, 4'd0, 2'd0, 4'd3},
    {1'b1, 5'd16, 2'd0, 4'd2, 2'd0, 4'd2, 2'd3, 4'd1},
    {1'b0, 5'd3,  2'd3, 4'd4, 2'd1, 4'd5, 2'd2, 4'd4},
    {1'b0, 5'd2,  2'd0, 4'd7, 2'd0, 4'd12, 2'd0, 4'd0},
    {1'b1, 5'd1,  2'd1, 4'd5, 2'd2, 4'd3, 2'd1, 4'd6},
    {1'b1, 5'd31, 2'd3, 4'd0, 2'd3, 4'd2, 2'd3, 4'd3}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      $display("FAIL watchdog: actual=%0d expected<=190000 cycles", cyc);
      bad = bad + 1;
      total = total + 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int bpre(input int c);
    case (c) 0: return 2; 1: return 3; 2: return 5; default: return 7; endcase
  endfunction
  function automatic int bscl(input int c);
    if (c < 4) return 2 * (c + 1);
    return 1 << c;
  endfunction
  function automatic int dly(input int p, input int s);
    return (2 * p + 1) * (2 << s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] v, input int restart_at);
    int p, hi, lo, nb, L, T, k, nedge, first, second, last;
    logic prev;
    nb = int'(v[22:18]);
    p  = bpre(int'(v[17:16])) * bscl(int'(v[15:12]));
    hi = p / 2;
    lo = p - hi;
    L  = dly(int'(v[11:10]), int'(v[9:6]));
    T  = dly(int'(v[5:4]), int'(v[3:0]));
    @(negedge clk);
    {cpol, frame_bits, baud_pre, baud_sc, lead_pre, lead_sc, trail_pre, trail_sc} = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    prev = v[23];
    k = 0; nedge = 0; first = -1; second = -1; last = 0;
    while (busy && k < 150000) begin
      if (sck !== prev) begin
        nedge++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
        last = k;
      end
      prev = sck;
      if (k == restart_at) begin
        start = 1'b1;
        frame_bits = 5'd1;
        baud_sc = 4'd0;
        trail_sc = 4'd0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start = 1'b0;
    chk(k == L + nb * p + T, "R6 busy length", k, L + nb * p + T);
    chk(nedge == 2 * nb, "R5 edge count", nedge, 2 * nb);
    if (nb > 0) begin
      chk(first == L + (v[23] ? hi : lo), "R3 lead to first edge", first, L + (v[23] ? hi : lo));
      chk(second - first == (v[23] ? lo : hi), "R1 second phase length", second - first, v[23] ? lo : hi);
      chk(k - last == T, "R4 trail after last edge", k - last, T);
    end else begin
      chk(first == -1, "R9 no edges for zero bits", first, -1);
    end
    chk(done === 1'b1, "R6 done after busy", int'(done), 1);
    chk(sck === v[23], "R5 sck ends at idle level", int'(sck), int'(v[23]));
    @(negedge clk);
    chk(done === 1'b0, "R6 done one cycle", int'(done), 0);
  endtask

  initial begin
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10 reset idle", int'({busy, done}), 0);
    chk(sck === 1'b1, "R10 reset sck level", int'(sck), 1);
    rst = 1'b0;
    @(negedge clk);
    cpol = 1'b0;
    @(negedge clk);
    chk(sck === 1'b0, "R8 idle sck follows cpol", int'(sck), 0);
    cpol = 1'b1;
    @(negedge clk);
    chk(sck === 1'b1, "R8 idle sck follows cpol", int'(sck), 1);

    for (int i = 0; i < 8; i++) run(VEC[i], -1);

    // R2: largest scaler code, P = 2*32768
    run({1'b0, 5'd1, 2'd0, 4'd15, 2'd0, 4'd0, 2'd0, 4'd0}, -1);
    // R9: zero-bit frame
    run({1'b1, 5'd0, 2'd0, 4'd0, 2'd2, 4'd1, 2'd1, 4'd2}, -1);
    // R7: restart strobe and attribute changes mid-frame are ignored
    run(VEC[1], 5);
    run(VEC[4], 200);

    // R10: reset in mid-frame
    @(negedge clk);
    {cpol, frame_bits, baud_pre, baud_sc, lead_pre, lead_sc, trail_pre, trail_sc} = VEC[3];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0 && done === 1'b0, "R10 reset stops frame", int'({busy, done}), 0);
    chk(sck === 1'b1, "R10 reset sck idle", int'(sck), 1);
    run(VEC[0], -1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule